// File: doc/BRIEF.md
# Double-Buffered Synthesizer Control-Word Loader

This block collects the 40-bit control word of a direct digital synthesizer through a narrow port and hands it to the oscillator core all at once. Software or a host controller fills a shadow rank in one of two ways. It can issue five 8-bit writes on a byte bus, or it can shift the 40 bits in one at a time on a serial data line, where each bit is qualified by a serial clock pulse. The shadow contents are a 32-bit frequency tuning word, a 5-bit phase offset, a power-down flag and a 2-bit format code.

The oscillator-facing outputs come from a second, active rank. That rank changes only when the separate update strobe is pulsed. On that pulse the complete shadow word is copied in a single clock cycle. The update timing has no link to the loading, so one update line can refresh many loaders in the same cycle. A small state machine tracks the progress of a load. Its states are `ST_IDLE` (no load in progress), `ST_BYTES` (between one and four bytes received) and `ST_SERIAL` (between one and 39 bits received).

The transitions are as follows:
- `ST_IDLE`→`ST_BYTES` on a byte write.
- `ST_IDLE`→`ST_SERIAL` on a serial bit.
- `ST_BYTES`→`ST_IDLE` on the fifth byte.
- `ST_SERIAL`→`ST_IDLE` on the fortieth bit.
- `ST_BYTES`→`ST_SERIAL` when a serial bit arrives, which abandons the byte load.
- `ST_SERIAL`→`ST_BYTES` when a byte write arrives, which abandons the serial load.

Top module: `dds_ctrl_loader`

## Requirements
- R1: A parallel load is five byte writes. The byte position counter advances on each write and wraps to the first position after the fifth write. `load_done` is 1 in the cycle after the fifth write.
- R2: The first byte of a parallel load fills the control fields: bits [7:3] become `phase_off`, bit 2 becomes `pwr_down` and bits [1:0] become `fmt`.
- R3: Parallel bytes two through five fill `tuning_word` most significant byte first: byte two goes to [31:24] and byte five goes to [7:0].
- R4: A serial load is 40 bits sent least significant first. Stream bit i lands in word bit i, where word [31:0] is the tuning word, [33:32] is the format, [34] is power-down and [39:35] is the phase offset. `load_done` is 1 in the cycle after the fortieth bit.
- R5: The active outputs hold their value in every cycle without an update pulse. The shadow word changes only on an accepted byte write or serial bit.
- R6: An update pulse copies the whole shadow word to the active outputs, and the outputs show it after that clock edge. If an update and a byte write fall in the same cycle, the outputs take the shadow value from before that write.
- R7: An update pulse issued during a partial load transfers the current shadow contents: the newly written bytes alongside the older bytes that have not been overwritten.
- R8: Reset clears the shadow rank, the active rank, the position counters and `load_done` to zero.
- R9: A byte write during a serial load, or a serial bit during a byte load, abandons the unfinished load and counts as the first element of a new load on the new path. A byte write wins over a serial bit in the same cycle.
- R10: `load_done` stays 1 until the next accepted byte write or serial bit, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_we | input | 1 | Byte write strobe |
| byte_data | input | 8 | Byte bus data |
| ser_tick | input | 1 | Serial clock pulse, one cycle per bit |
| ser_data | input | 1 | Serial data bit |
| update | input | 1 | Copy the shadow rank into the active rank |
| tuning_word | output | 32 | Active frequency tuning word |
| phase_off | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| fmt | output | 2 | Active format code |
| load_done | output | 1 | Last load completed with no transfer since |

## Verification
Some behaviour is checked by assertions on every cycle:
- The active rank holds without an update and equals the prior shadow word after one.
- The shadow rank holds without a transfer.
- The two counters stay within range.
- `load_done` drops on the next transfer.

Field placement, byte order, serial bit order, the result of an update during a partial load, path switching and the reset contents depend on particular data patterns. Only the bench scenarios can show those, by comparing the outputs against words it assembles itself.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
    localparam int NUM_BYTES = 5;
    localparam int WORD_W    = NUM_BYTES * 8;
    localparam int FTW_W     = 32;
    localparam int PH_W      = 5;
    localparam int FMT_W     = 2;
    localparam int BCNT_W    = $clog2(NUM_BYTES);
    localparam int SCNT_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BYTES  = 2'd1,
        ST_SERIAL = 2'd2
    } ldr_state_t;
endpackage

// File: rtl/dds_ldr_fsm.sv
module dds_ldr_fsm
    import dds_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic              ser_tick,
    output logic              do_byte,
    output logic              do_shift,
    output logic [BCNT_W-1:0] byte_slot,
    output logic              load_done
);
    localparam logic [BCNT_W-1:0] BYTE_LAST = BCNT_W'(NUM_BYTES - 1);
    localparam logic [SCNT_W-1:0] BIT_LAST  = SCNT_W'(WORD_W - 1);

    ldr_state_t        state_q, state_d;
    logic [BCNT_W-1:0] bcnt_q, bcnt_d;
    logic [SCNT_W-1:0] scnt_q, scnt_d;
    logic              done_q, done_d;

    // byte path wins over serial path in the same cycle
    assign do_byte  = byte_we;
    assign do_shift = ser_tick && !byte_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            scnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
            scnt_q  <= scnt_d;
            done_q  <= done_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q;
        scnt_d  = scnt_q;
        done_d  = done_q;
        if (do_byte || do_shift) done_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (do_byte) begin
                    state_d = ST_BYTES;
                    bcnt_d  = BCNT_W'(1);
                end else if (do_shift) begin
                    state_d = ST_SERIAL;
                    scnt_d  = SCNT_W'(1);
                end
            end
            ST_BYTES: begin
                if (do_byte) begin
                    if (bcnt_q == BYTE_LAST) begin
                        state_d = ST_IDLE;
                        bcnt_d  = '0;
                        done_d  = 1'b1;
                    end else begin
                        bcnt_d = bcnt_q + BCNT_W'(1);
                    end
                end else if (do_shift) begin
                    state_d = ST_SERIAL;
                    bcnt_d  = '0;
                    scnt_d  = SCNT_W'(1);
                end
            end
            ST_SERIAL: begin
                if (do_byte) begin
                    state_d = ST_BYTES;
                    scnt_d  = '0;
                    bcnt_d  = BCNT_W'(1);
                end else if (do_shift) begin
                    if (scnt_q == BIT_LAST) begin
                        state_d = ST_IDLE;
                        scnt_d  = '0;
                        done_d  = 1'b1;
                    end else begin
                        scnt_d = scnt_q + SCNT_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        byte_slot = (state_q == ST_BYTES) ? bcnt_q : '0;
        load_done = done_q;
    end

    p_byte_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_q <= BYTE_LAST);
    p_bit_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scnt_q <= BIT_LAST);
    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (byte_we || ser_tick)) |=> !done_q);
    p_byte_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERIAL && byte_we) |=> (state_q == ST_BYTES && bcnt_q == BCNT_W'(1)));
endmodule

// File: rtl/dds_ldr_shadow.sv
module dds_ldr_shadow
    import dds_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_byte,
    input  logic              do_shift,
    input  logic [BCNT_W-1:0] byte_slot,
    input  logic [7:0]        byte_data,
    input  logic              ser_data,
    output logic [WORD_W-1:0] shadow
);
    logic [WORD_W-1:0] sh_q;
    int                lane;

    // slot 0 is the top byte of the word, later slots step downward
    always_comb lane = (NUM_BYTES - 1) - int'(byte_slot);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (do_byte) begin
            sh_q[lane*8 +: 8] <= byte_data;
        end else if (do_shift) begin
            sh_q <= {ser_data, sh_q[WORD_W-1:1]};
        end
    end

    assign shadow = sh_q;

    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_byte || do_shift) |=> $stable(sh_q));
endmodule

// File: rtl/dds_ldr_active.sv
module dds_ldr_active
    import dds_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update,
    input  logic [WORD_W-1:0] shadow,
    output logic [WORD_W-1:0] active
);
    logic [WORD_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (update) act_q <= shadow;
    end

    assign active = act_q;

    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(act_q));
    p_update_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (act_q == $past(shadow)));
endmodule

// File: rtl/dds_ctrl_loader.sv
module dds_ctrl_loader
    import dds_ldr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [7:0]       byte_data,
    input  logic             ser_tick,
    input  logic             ser_data,
    input  logic             update,
    output logic [FTW_W-1:0] tuning_word,
    output logic [PH_W-1:0]  phase_off,
    output logic             pwr_down,
    output logic [FMT_W-1:0] fmt,
    output logic             load_done
);
    localparam int FMT_LSB = FTW_W;
    localparam int PD_BIT  = FTW_W + FMT_W;
    localparam int PH_LSB  = PD_BIT + 1;

    logic              do_byte, do_shift;
    logic [BCNT_W-1:0] byte_slot;
    logic [WORD_W-1:0] shadow, active;

    dds_ldr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (byte_we),
        .ser_tick  (ser_tick),
        .do_byte   (do_byte),
        .do_shift  (do_shift),
        .byte_slot (byte_slot),
        .load_done (load_done)
    );

    dds_ldr_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_byte   (do_byte),
        .do_shift  (do_shift),
        .byte_slot (byte_slot),
        .byte_data (byte_data),
        .ser_data  (ser_data),
        .shadow    (shadow)
    );

    dds_ldr_active u_active (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (update),
        .shadow (shadow),
        .active (active)
    );

    assign tuning_word = active[FTW_W-1:0];
    assign fmt         = active[FMT_LSB +: FMT_W];
    assign pwr_down    = active[PD_BIT];
    assign phase_off   = active[PH_LSB +: PH_W];
endmodule

// File: tb/dds_ctrl_loader_tb.sv
module dds_ctrl_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_we = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        ser_tick = 1'b0;
    logic        ser_data = 1'b0;
    logic        update = 1'b0;
    logic [31:0] tuning_word;
    logic [4:0]  phase_off;
    logic        pwr_down;
    logic [1:0]  fmt;
    logic        load_done;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    dds_ctrl_loader u_dut (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_data(byte_data),
        .ser_tick(ser_tick), .ser_data(ser_data), .update(update),
        .tuning_word(tuning_word), .phase_off(phase_off), .pwr_down(pwr_down),
        .fmt(fmt), .load_done(load_done)
    );

    // bit 40 selects the path (1 = serial), bits 39:0 the word
    localparam logic [40:0] VEC [6] = '{
        {1'b0, 40'hA5_1234_5678},
        {1'b1, 40'h3C_DEAD_BEEF},
        {1'b0, 40'hFF_FFFF_FFFF},
        {1'b1, 40'h81_0000_0001},
        {1'b0, 40'h04_8000_0000},
        {1'b1, 40'h7E_0F0F_F0F0}
    };

    function automatic logic [39:0] outw();
        return {phase_off, pwr_down, fmt, tuning_word};
    endfunction

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); byte_we = 1'b1; byte_data = b;
        @(negedge clk); byte_we = 1'b0;
    endtask

    task automatic sh_bit(input logic b);
        @(negedge clk); ser_tick = 1'b1; ser_data = b;
        @(negedge clk); ser_tick = 1'b0;
    endtask

    task automatic load_bytes(input logic [39:0] w);
        for (int k = 0; k < 5; k++) wr_byte(w[(4-k)*8 +: 8]);
    endtask

    task automatic load_serial(input logic [39:0] w);
        for (int i = 0; i < 40; i++) sh_bit(w[i]);
    endtask

    task automatic pulse_update();
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] prev, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset outputs", outw(), 40'h0);
        chk("R8 reset done", {39'h0, load_done}, 40'h0);

        // table walk: load, outputs untouched, update, outputs equal word
        prev = 40'h0;
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][40]) load_serial(VEC[v][39:0]);
            else            load_bytes(VEC[v][39:0]);
            chk(VEC[v][40] ? "R4 serial done" : "R1 byte done", {39'h0, load_done}, 40'h1);
            chk("R5 no update hold", outw(), prev);
            pulse_update();
            chk(VEC[v][40] ? "R4 serial word" : "R2 R3 byte word", outw(), VEC[v][39:0]);
            prev = VEC[v][39:0];
        end

        // field placement from a control byte: phase=10110, pd=1, fmt=01
        load_bytes(40'hB5_0102_0304);
        pulse_update();
        chk("R2 phase field", {35'h0, phase_off}, 40'h16);
        chk("R2 pd/fmt", {37'h0, pwr_down, fmt}, 40'h5);
        chk("R3 tuning order", {8'h0, tuning_word}, 40'h01020304);

        // R10: next transfer clears done
        wr_byte(8'h11);
        chk("R10 done cleared", {39'h0, load_done}, 40'h0);
        // R7: partial load (2 bytes) then update
        wr_byte(8'h22);
        pulse_update();
        chk("R7 partial update", outw(), 40'h11_2202_0304);

        // R9: abandon byte load with a full serial load
        a = 40'hC3_9876_5432;
        load_serial(a);
        chk("R9 serial after bytes done", {39'h0, load_done}, 40'h1);
        pulse_update();
        chk("R9 serial after bytes word", outw(), a);

        // R9: 10 serial bits then a full byte load
        for (int i = 0; i < 10; i++) sh_bit(1'b1);
        b = 40'h5A_CAFE_F00D;
        load_bytes(b);
        chk("R9 bytes after serial done", {39'h0, load_done}, 40'h1);
        pulse_update();
        chk("R9 bytes after serial word", outw(), b);

        // R9 priority: byte and serial in the same cycle, byte is taken
        @(negedge clk); byte_we = 1'b1; byte_data = 8'h99; ser_tick = 1'b1; ser_data = 1'b0;
        @(negedge clk); byte_we = 1'b0; ser_tick = 1'b0;
        for (int k = 1; k < 5; k++) wr_byte(8'h10 + 8'(k));
        chk("R9 priority done", {39'h0, load_done}, 40'h1);
        pulse_update();
        chk("R9 priority word", outw(), 40'h99_1112_1314);

        // R6: update coincides with a byte write, old shadow copied
        @(negedge clk); update = 1'b1; byte_we = 1'b1; byte_data = 8'hEE;
        @(negedge clk); update = 1'b0; byte_we = 1'b0;
        chk("R6 same-cycle update", outw(), 40'h99_1112_1314);
        pulse_update();
        chk("R6 later update", outw(), 40'hEE_1112_1314);

        // R8: reset mid-load clears both ranks and counters
        wr_byte(8'h77);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 reset active", outw(), 40'h0);
        pulse_update();
        chk("R8 reset shadow", outw(), 40'h0);
        wr_byte(8'hAB);
        pulse_update();
        chk("R8 counter restart", outw(), 40'hAB_0000_0000);

        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule